// File: doc/BRIEF.md
# Display Buffer Scan Address Generator

This block generates memory fetch addresses for a display buffer that is organised in scan lines inside a graphics aperture of up to 4 MB. Software programs an aperture base, start offsets for the uncompressed frame buffer, the compressed buffer and the cursor pattern, and per-line strides counted in DWORDs. The display timing logic then drives three pulses. `frame_start` rewinds the line pointers. `line_start` launches the DWORD walk of one scan line. `cur_restart` and `cur_step` drive a linear cursor fetch.

Each line start is the previous line start plus a programmable stride. The stride may equal the line length, which stores the buffer as one linear block. It may also be larger, which leaves padding after each line and gives a logical block. The coarse frame buffer start (16-byte granule) is picked up only when a frame starts, so panning or page flipping never tears a frame. The sub-16-byte pixel offset goes to the pixel pipeline as soon as it is written.

Top module: `dbuf_scan_agen`

## Requirements
- R1: After reset every register reads zero, `fetch_valid` is low, and `fetch_addr`, `fb_line_addr`, `cb_line_addr`, `cur_addr` and `pix_offset` are zero.
- R2: Register readback masks: index 0 (frame start) keeps bits 21:0. Index 1 (compressed start) and index 4 (video start) keep bits 21:4 and read zero in bits 3:0. Index 2 (cursor start) keeps bits 21:2. Index 3 always reads zero. Index 5 (strides) keeps the compressed stride in bits 21:12 and the frame stride in bits 9:0. Index 6 (base) keeps bits 31:22. Index 7 (line length in DWORDs) keeps bits 9:0.
- R3: `pix_offset` shows bits 3:0 of the frame start register from the cycle after the write, with no frame start needed.
- R4: Bits 21:4 of the frame start register reach the line pointer only on `frame_start`. A write in the same cycle as `frame_start` is used from the following frame on.
- R5: The k-th `line_start` after a frame start (k from 0) fetches from offset start + 4·k·stride, where start is the frame start with bits 3:0 cleared. `fb_line_addr` shows that line start from the cycle after the pulse.
- R6: After a `line_start`, `fetch_valid` is high for exactly `len` consecutive cycles, starting the next cycle. The offset rises by 4 each cycle. A length of 0 gives no fetch.
- R7: `cb_line_addr` shows the compressed start plus 4·k·compressed stride for the k-th line, from the cycle after its `line_start`.
- R8: Every address is {base bits 31:22, offset bits 21:0}. Offsets wrap modulo 4 MB and never disturb the base bits.
- R9: `cur_restart` loads the cursor offset into `cur_addr`. Each `cur_step` adds 4. Restart wins when both are asserted.
- R10: A `line_start` during a walk abandons it and starts the next line on the following cycle.
- R11: A `frame_start` during a walk ends it: `fetch_valid` is low on the following cycle. A `line_start` in the same cycle as `frame_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of register `reg_idx` (combinational) |
| frame_start | input | 1 | Start of frame scan pulse |
| line_start | input | 1 | Start of scan line pulse |
| cur_restart | input | 1 | Rewind cursor fetch pointer |
| cur_step | input | 1 | Advance cursor fetch pointer one DWORD |
| fetch_valid | output | 1 | Frame buffer fetch address valid |
| fetch_addr | output | 32 | Frame buffer fetch byte address |
| fb_line_addr | output | 32 | Start address of current frame buffer line |
| cb_line_addr | output | 32 | Start address of current compressed line |
| cur_addr | output | 32 | Cursor fetch byte address |
| pix_offset | output | 4 | Sub-16-byte pixel offset |

## Verification
The assertions check the local step rules on every cycle. Within a walk the offset rises by 4. A walk ends on its last DWORD and a frame start kills it. A launched line begins at the pending line pointer. That pointer holds between pulses, the cursor steps by 4, and the pixel offset follows writes. The absolute values need the bench scenarios. These include the k-th line start for linear and padded strides, wrap at 4 MB, and the frame in which a write coinciding with a frame start becomes visible. The bench also covers the masks, the restart of a line in mid-walk and the zero-length line.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [2:0] {
    RI_FB    = 3'd0,
    RI_CB    = 3'd1,
    RI_CUR   = 3'd2,
    RI_RSV   = 3'd3,
    RI_VID   = 3'd4,
    RI_DELTA = 3'd5,
    RI_BASE  = 3'd6,
    RI_LEN   = 3'd7
  } reg_idx_e;

  // Low n bits set.
  function automatic logic [31:0] low_ones(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

  // Advance a byte offset by a DWORD count, wrapping inside the aperture.
  function automatic logic [31:0] dword_step(input logic [31:0] ofs,
                                             input logic [31:0] dwords,
                                             input int unsigned ofs_w);
    return (ofs + (dwords << 2)) & low_ones(ofs_w);
  endfunction

  // Writable bits of each register.
  function automatic logic [31:0] reg_mask(input logic [2:0] idx,
                                           input int unsigned ofs_w,
                                           input int unsigned delta_w,
                                           input int unsigned len_w,
                                           input int unsigned cb_lsb);
    logic [31:0] m;
    case (reg_idx_e'(idx))
      RI_FB:    m = low_ones(ofs_w);
      RI_CB,
      RI_VID:   m = low_ones(ofs_w) & ~32'hF;
      RI_CUR:   m = low_ones(ofs_w) & ~32'h3;
      RI_DELTA: m = (low_ones(delta_w) << cb_lsb) | low_ones(delta_w);
      RI_BASE:  m = ~low_ones(ofs_w);
      RI_LEN:   m = low_ones(len_w);
      default:  m = 32'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/agen_regs.sv
module agen_regs
  import agen_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OFS_W   = 22,
  parameter int DELTA_W = 10,
  parameter int LEN_W   = 10,
  parameter int CB_LSB  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [2:0]               idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [OFS_W-1:0]         fb_ofs,
  output logic [OFS_W-1:0]         cb_ofs,
  output logic [OFS_W-1:0]         cur_ofs,
  output logic [DELTA_W-1:0]       fb_delta,
  output logic [DELTA_W-1:0]       cb_delta,
  output logic [DATA_W-OFS_W-1:0]  base,
  output logic [LEN_W-1:0]         line_len
);
  localparam int NREG = 8;

  logic [DATA_W-1:0] regq [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regq[i] <= '0;
    end else if (we) begin
      regq[idx] <= wdata & DATA_W'(reg_mask(idx, OFS_W, DELTA_W, LEN_W, CB_LSB));
    end
  end

  assign rdata    = regq[idx];
  assign fb_ofs   = regq[RI_FB][OFS_W-1:0];
  assign cb_ofs   = regq[RI_CB][OFS_W-1:0];
  assign cur_ofs  = regq[RI_CUR][OFS_W-1:0];
  assign fb_delta = regq[RI_DELTA][DELTA_W-1:0];
  assign cb_delta = regq[RI_DELTA][CB_LSB+DELTA_W-1:CB_LSB];
  assign base     = regq[RI_BASE][DATA_W-1:OFS_W];
  assign line_len = regq[RI_LEN][LEN_W-1:0];

endmodule

// File: rtl/agen_line_ptr.sv
module agen_line_ptr
  import agen_pkg::*;
#(
  parameter int OFS_W   = 22,
  parameter int DELTA_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic [OFS_W-1:0]   start,
  input  logic [DELTA_W-1:0] delta,
  output logic [OFS_W-1:0]   next_ptr,
  output logic [OFS_W-1:0]   cur_ptr
);
  // next_ptr: start of the line the next line_start launches.
  // cur_ptr : start of the line launched last.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_ptr <= '0;
      cur_ptr  <= '0;
    end else if (frame_start) begin
      next_ptr <= start;
    end else if (line_start) begin
      cur_ptr  <= next_ptr;
      next_ptr <= OFS_W'(dword_step(32'(next_ptr), 32'(delta), OFS_W));
    end
  end

endmodule

// File: rtl/agen_walker.sv
module agen_walker
  import agen_pkg::*;
#(
  parameter int OFS_W = 22,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic [OFS_W-1:0] line_ptr,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic [OFS_W-1:0] ptr,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  assign last = busy && (LEN_W'(cnt + 1'b1) == len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ptr  <= '0;
    end else if (frame_start) begin
      busy <= 1'b0;
    end else if (line_start) begin
      busy <= (len != '0);
      cnt  <= '0;
      ptr  <= line_ptr;
    end else if (busy) begin
      busy <= !last;
      cnt  <= LEN_W'(cnt + 1'b1);
      ptr  <= OFS_W'(dword_step(32'(ptr), 32'd1, OFS_W));
    end
  end

endmodule

// File: rtl/agen_cursor.sv
module agen_cursor
  import agen_pkg::*;
#(
  parameter int OFS_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [OFS_W-1:0] start,
  output logic [OFS_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (restart) ptr <= start;
    else if (step)    ptr <= OFS_W'(dword_step(32'(ptr), 32'd1, OFS_W));
  end

endmodule

// File: rtl/dbuf_scan_agen.sv
module dbuf_scan_agen #(
  parameter int DATA_W  = 32,
  parameter int OFS_W   = 22,
  parameter int DELTA_W = 10,
  parameter int LEN_W   = 10,
  parameter int CB_LSB  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              cur_restart,
  input  logic              cur_step,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] fb_line_addr,
  output logic [DATA_W-1:0] cb_line_addr,
  output logic [DATA_W-1:0] cur_addr,
  output logic [3:0]        pix_offset
);
  localparam int BASE_W = DATA_W - OFS_W;
  localparam int NBUF   = 2;   // 0: frame buffer, 1: compressed buffer

  logic [OFS_W-1:0]   fb_ofs, cb_ofs, cur_ofs;
  logic [DELTA_W-1:0] fb_delta, cb_delta;
  logic [BASE_W-1:0]  base;
  logic [LEN_W-1:0]   line_len;

  agen_regs #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .DELTA_W(DELTA_W),
    .LEN_W(LEN_W), .CB_LSB(CB_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .fb_ofs(fb_ofs), .cb_ofs(cb_ofs), .cur_ofs(cur_ofs),
    .fb_delta(fb_delta), .cb_delta(cb_delta),
    .base(base), .line_len(line_len)
  );

  logic [OFS_W-1:0]   lp_start [NBUF];
  logic [DELTA_W-1:0] lp_delta [NBUF];
  logic [OFS_W-1:0]   lp_next  [NBUF];
  logic [OFS_W-1:0]   lp_cur   [NBUF];

  assign lp_start[0] = {fb_ofs[OFS_W-1:4], 4'b0000};
  assign lp_start[1] = cb_ofs;
  assign lp_delta[0] = fb_delta;
  assign lp_delta[1] = cb_delta;

  for (genvar g = 0; g < NBUF; g++) begin : g_lp
    agen_line_ptr #(.OFS_W(OFS_W), .DELTA_W(DELTA_W)) u_lp (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .line_start(line_start),
      .start(lp_start[g]), .delta(lp_delta[g]),
      .next_ptr(lp_next[g]), .cur_ptr(lp_cur[g])
    );
  end

  // Named events for the checker.
  logic             walk_last;
  logic [OFS_W-1:0] fb_next;
  logic [OFS_W-1:0] walk_ptr;
  logic [OFS_W-1:0] cur_ptr;

  assign fb_next = lp_next[0];

  agen_walker #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .line_start(line_start),
    .line_ptr(fb_next), .len(line_len),
    .busy(fetch_valid), .ptr(walk_ptr), .last(walk_last)
  );

  agen_cursor #(.OFS_W(OFS_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .restart(cur_restart), .step(cur_step),
    .start(cur_ofs), .ptr(cur_ptr)
  );

  assign fetch_addr   = {base, walk_ptr};
  assign fb_line_addr = {base, lp_cur[0]};
  assign cb_line_addr = {base, lp_cur[1]};
  assign cur_addr     = {base, cur_ptr};
  assign pix_offset   = fb_ofs[3:0];

endmodule

// File: rtl/dbuf_scan_agen_chk.sv
module dbuf_scan_agen_chk #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 22,
  parameter int LEN_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              frame_start,
  input logic              line_start,
  input logic              cur_restart,
  input logic              cur_step,
  input logic              fetch_valid,
  input logic [DATA_W-1:0] fetch_addr,
  input logic [DATA_W-1:0] cur_addr,
  input logic [3:0]        pix_offset,
  input logic              walk_last,
  input logic [OFS_W-1:0]  fb_next,
  input logic [LEN_W-1:0]  line_len
);

  p_pix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == 3'd0) |=> pix_offset == $past(reg_wdata[3:0]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start) |=> $stable(fb_next));

  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && line_len != '0) |=>
      (fetch_valid && fetch_addr[OFS_W-1:0] == $past(fb_next)));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !walk_last && !line_start && !frame_start) |=>
      (fetch_valid &&
       fetch_addr[OFS_W-1:0] == OFS_W'($past(fetch_addr[OFS_W-1:0]) + 4)));

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_last && !line_start && !frame_start) |=> !fetch_valid);

  p_cursor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step && !cur_restart) |=>
      cur_addr[OFS_W-1:0] == OFS_W'($past(cur_addr[OFS_W-1:0]) + 4));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !fetch_valid);

endmodule

bind dbuf_scan_agen dbuf_scan_agen_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .frame_start(frame_start), .line_start(line_start),
  .cur_restart(cur_restart), .cur_step(cur_step),
  .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .cur_addr(cur_addr),
  .pix_offset(pix_offset), .walk_last(walk_last), .fb_next(fb_next),
  .line_len(line_len)
);

// File: tb/dbuf_scan_agen_tb.sv
`timescale 1ns/1ps
module dbuf_scan_agen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0, line_start = 1'b0;
  logic        cur_restart = 1'b0, cur_step = 1'b0;
  logic        fetch_valid;
  logic [31:0] fetch_addr, fb_line_addr, cb_line_addr, cur_addr;
  logic [3:0]  pix_offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbuf_scan_agen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_start(frame_start), .line_start(line_start),
    .cur_restart(cur_restart), .cur_step(cur_step),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fb_line_addr(fb_line_addr), .cb_line_addr(cb_line_addr),
    .cur_addr(cur_addr), .pix_offset(pix_offset)
  );

  typedef struct packed {
    logic [9:0]  base;
    logic [21:0] start;
    logic [9:0]  delta;
    logic [9:0]  len;
    logic [31:0] line2;   // expected start address of line index 2
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{10'd1, 22'h000100, 10'd16, 10'd16, 32'h0040_0180},  // linear
    '{10'd3, 22'h001000, 10'd40, 10'd16, 32'h00C0_1140},  // padded
    '{10'd0, 22'h3FFFF0, 10'd8,  10'd4,  32'h0000_0030},  // wraps at 4 MB
    '{10'd2, 22'h000207, 10'd1,  10'd1,  32'h0080_0208}   // stride 1, pixel bits set
  };

  localparam logic [21:0] CB_START = 22'h010000;

  // Reference: line k, DWORD i, as a byte address.
  function automatic logic [31:0] ref_addr(input logic [9:0] b, input logic [21:0] s,
                                           input int d, input int k, input int i);
    longint o;
    o = (longint'(s) / 16) * 16 + longint'(k) * d * 4 + longint'(i) * 4;
    o = o % 4194304;
    return (32'(b) << 22) + 32'(o);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string req);
    reg_idx = idx;
    #0.5;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1; tick(); line_start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    for (int r = 0; r < 8; r++) rd_chk(3'(r), 32'd0, "R1 reg reset");
    chk(fetch_valid == 1'b0, "R1 fetch_valid", 32'(fetch_valid), 32'd0);
    chk(fetch_addr == 0 && fb_line_addr == 0 && cb_line_addr == 0 && cur_addr == 0,
        "R1 addresses", fetch_addr | fb_line_addr | cb_line_addr | cur_addr, 32'd0);
    chk(pix_offset == 4'd0, "R1 pix_offset", 32'(pix_offset), 32'd0);

    // Vector table: linear, padded, wrapping frames (R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      wr(3'd6, 32'(VECS[v].base) << 22);
      wr(3'd7, 32'(VECS[v].len));
      wr(3'd5, (32'(VECS[v].delta + 10'd3) << 12) | 32'(VECS[v].delta));
      wr(3'd0, 32'(VECS[v].start));
      wr(3'd1, 32'(CB_START));
      pulse_frame();
      for (int k = 0; k < 3; k++) begin
        pulse_line();
        chk(fb_line_addr == ref_addr(VECS[v].base, VECS[v].start, VECS[v].delta, k, 0),
            "R5 fb line start", fb_line_addr,
            ref_addr(VECS[v].base, VECS[v].start, VECS[v].delta, k, 0));
        chk(cb_line_addr == ref_addr(VECS[v].base, CB_START, VECS[v].delta + 3, k, 0),
            "R7 cb line start", cb_line_addr,
            ref_addr(VECS[v].base, CB_START, VECS[v].delta + 3, k, 0));
        if (k == 2)
          chk(fetch_addr == VECS[v].line2, "R8 line2 vector", fetch_addr, VECS[v].line2);
        for (int i = 0; i < int'(VECS[v].len); i++) begin
          chk(fetch_valid && fetch_addr ==
                ref_addr(VECS[v].base, VECS[v].start, VECS[v].delta, k, i),
              "R6 walk address", fetch_addr,
              ref_addr(VECS[v].base, VECS[v].start, VECS[v].delta, k, i));
          tick();
        end
        chk(!fetch_valid, "R6 walk ends", 32'(fetch_valid), 32'd0);
      end
    end

    // R2: readback masks
    wr(3'd3, 32'hFFFF_FFFF); rd_chk(3'd3, 32'h0000_0000, "R2 reserved");
    wr(3'd1, 32'hFFFF_FFFF); rd_chk(3'd1, 32'h003F_FFF0, "R2 cb start");
    wr(3'd4, 32'hFFFF_FFFF); rd_chk(3'd4, 32'h003F_FFF0, "R2 video start");
    wr(3'd2, 32'hFFFF_FFFF); rd_chk(3'd2, 32'h003F_FFFC, "R2 cursor start");
    wr(3'd5, 32'hFFFF_FFFF); rd_chk(3'd5, 32'h003F_F3FF, "R2 strides");
    wr(3'd0, 32'hFFFF_FFFF); rd_chk(3'd0, 32'h003F_FFFF, "R2 fb start");
    wr(3'd6, 32'hFFFF_FFFF); rd_chk(3'd6, 32'hFFC0_0000, "R2 base");
    wr(3'd7, 32'hFFFF_FFFF); rd_chk(3'd7, 32'h0000_03FF, "R2 length");

    // R3 / R4: pixel offset now, coarse start at next frame
    wr(3'd6, 32'd0);
    wr(3'd7, 32'd2);
    wr(3'd5, 32'd8);
    wr(3'd0, 32'h100);
    pulse_frame();
    wr(3'd0, 32'h20A);
    chk(pix_offset == 4'hA, "R3 pix immediate", 32'(pix_offset), 32'hA);
    pulse_line();
    chk(fetch_addr == 32'h100, "R4 coarse waits for frame", fetch_addr, 32'h100);
    reg_we = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h300; frame_start = 1'b1;
    tick();
    reg_we = 1'b0; frame_start = 1'b0;
    pulse_line();
    chk(fetch_addr == 32'h200, "R4 same-cycle write deferred", fetch_addr, 32'h200);
    pulse_frame();
    pulse_line();
    chk(fetch_addr == 32'h300, "R4 next frame uses write", fetch_addr, 32'h300);

    // R10: line start during a walk
    wr(3'd7, 32'd8);
    pulse_frame();
    pulse_line();
    tick();
    chk(fetch_addr == 32'h304, "R10 walking", fetch_addr, 32'h304);
    pulse_line();
    chk(fetch_valid && fetch_addr == 32'h320, "R10 restart next line", fetch_addr, 32'h320);

    // R11: frame start during a walk; same-cycle line start ignored
    pulse_frame();
    chk(!fetch_valid, "R11 frame kills walk", 32'(fetch_valid), 32'd0);
    frame_start = 1'b1; line_start = 1'b1;
    tick();
    frame_start = 1'b0; line_start = 1'b0;
    chk(!fetch_valid, "R11 line with frame ignored", 32'(fetch_valid), 32'd0);
    pulse_line();
    chk(fetch_addr == 32'h300, "R11 first line after frame", fetch_addr, 32'h300);

    // R6: zero length gives no fetch
    wr(3'd7, 32'd0);
    pulse_line();
    chk(!fetch_valid, "R6 zero length", 32'(fetch_valid), 32'd0);

    // R9 / R8: cursor linear walk with wrap
    wr(3'd6, 32'h0140_0000);
    wr(3'd2, 32'h003F_FFF8);
    cur_restart = 1'b1; cur_step = 1'b1;
    tick();
    cur_restart = 1'b0;
    chk(cur_addr == 32'h017F_FFF8, "R9 restart wins", cur_addr, 32'h017F_FFF8);
    tick();
    chk(cur_addr == 32'h017F_FFFC, "R9 step", cur_addr, 32'h017F_FFFC);
    tick();
    cur_step = 1'b0;
    chk(cur_addr == 32'h0140_0000, "R8 cursor wrap", cur_addr, 32'h0140_0000);
    tick();
    chk(cur_addr == 32'h0140_0000, "R9 hold without step", cur_addr, 32'h0140_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule